// File: doc/BRIEF.md
# SPI Slave Port with Overrun and Underrun Events

This block is the serial side of an SPI target device. A one-word transmit holding register and a one-word receive buffer sit between a system-clock register interface and a shift engine. The shift engine is driven by an external master through `sck_i`, `mosi_i` and the active-low select `ssel_n_i`, and it drives `miso_o`. Software writes a word with `tx_wr_i` whenever `tx_ready_o` is high. It reads the last complete frame from `rx_data_o` and acknowledges it with `rx_rd_i` whenever `rx_ready_o` is high.

All three serial inputs pass through two-flop synchronisers into the system clock domain. Edges are detected there, so the system clock must run at least four times as fast as SCK. The serial timing is mode 0: the master drives SCK low when idle, the slave samples MOSI on the rising edge and changes MISO on the falling edge, and data is sent most significant bit first. The frame length is a parameter and defaults to 8 bits.

Two error events go to a status block as one-cycle pulses. `ovr_evt_o` marks a frame that begins while the receive buffer is still unread. `udr_evt_o` marks a frame that must start while the holding register is empty. After either event the data is undefined until software clears the block by dropping `en_i`.

Top module: `spi_slave_port`

## Requirements
- R1: While reset or `en_i` low is in force, `tx_ready_o`=1, `rx_ready_o`=0, `miso_o`=0 and both event outputs are 0.
- R2: The bits on MOSI are sampled on the rising SCK edges of a selected frame, MSB first. After the FRAME_W-th bit, `rx_ready_o` goes to 1 and `rx_data_o` holds the frame.
- R3: `rx_rd_i` while `rx_ready_o`=1 clears `rx_ready_o` on the next cycle.
- R4: An accepted `tx_wr_i` drops `tx_ready_o` on the next cycle. `tx_ready_o` rises again once the word is moved into the shift register.
- R5: A frame starts at each load point: the assertion of select, and the falling SCK edge that ends a frame while select stays low. At a load point the holding word moves to the shifter, and MISO then gives it MSB first, changing after falling edges.
- R6: When a frame's first rising SCK edge comes while `rx_ready_o`=1, `ovr_evt_o` pulses for one cycle. The incoming frame is discarded, and `rx_data_o` and `rx_ready_o` are kept.
- R7: A load point with an empty holding register pulses `udr_evt_o` for one cycle, and MISO sends all zeros for that frame.
- R8: Releasing select before the last bit of a frame discards the partial frame without setting `rx_ready_o`. The next selection starts a fresh, aligned frame.
- R9: Driving `en_i` low clears the state: `rx_ready_o` goes to 0 and any word waiting in the holding register is discarded, so the next frame underruns.
- R10: `tx_wr_i` while `tx_ready_o`=0 is ignored, and the word already held is the one transmitted.
- R11: Frames sent back to back under one selection each take the next holding word and each deliver their own received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; low clears all state |
| sck_i | input | 1 | Serial clock from master (idle low) |
| mosi_i | input | 1 | Serial data from master |
| ssel_n_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data to master |
| tx_wr_i | input | 1 | Write strobe for the holding register |
| tx_data_i | input | FRAME_W | Word to transmit |
| tx_ready_o | output | 1 | Holding register free |
| rx_rd_i | input | 1 | Read acknowledge for the receive buffer |
| rx_data_o | output | FRAME_W | Last received frame |
| rx_ready_o | output | 1 | Receive buffer holds an unread frame |
| ovr_evt_o | output | 1 | Receive overrun pulse |
| udr_evt_o | output | 1 | Transmit underrun pulse |

## Verification
A bit counter that slips out of step with the master appears on the next frame. The received word comes out rotated, and MISO bits arrive one SCK period early or late. A stale drop flag shows as a missing `rx_ready_o` after an otherwise clean frame, within about five system clocks of the last rising edge. Wrong holding-register state shows at the next load point, either as a spurious or missing `udr_evt_o` pulse or as the wrong word on MISO. It also shows as `tx_ready_o` failing to rise a few cycles after select is asserted.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  // Serial lines gathered into one vector for the synchroniser.
  typedef struct packed {
    logic ssel_n;
    logic sck;
    logic mosi;
  } spi_lines_t;

  localparam int LINES_W = $bits(spi_lines_t);
  // Idle value of the lines: deselected, clock low, data low.
  localparam logic [LINES_W-1:0] LINES_IDLE = 3'b100;
endpackage

// File: rtl/spi_slave_sync.sv
module spi_slave_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] src;
      if (g == 0) begin : g_first
        assign src = d_i;
      end else begin : g_next
        assign src = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     stage_q[g] <= IDLE;
        else if (!en_i) stage_q[g] <= IDLE;
        else            stage_q[g] <= src;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_slave_shifter.sv
module spi_slave_shifter #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               sck_s,
  input  logic               ssel_n_s,
  input  logic               mosi_s,
  input  logic               rx_full_i,
  input  logic               tx_full_i,
  input  logic [FRAME_W-1:0] tx_word_i,
  output logic               miso_o,
  output logic               evt_start_o,
  output logic               evt_push_o,
  output logic [FRAME_W-1:0] push_data_o,
  output logic               evt_take_o,
  output logic               evt_udr_o,
  output logic               evt_ovr_o
);
  localparam int CW = (FRAME_W > 2) ? $clog2(FRAME_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

  function automatic logic [FRAME_W-1:0] shift_in(input logic [FRAME_W-1:0] v, input logic b);
    return {v[FRAME_W-2:0], b};
  endfunction

  function automatic logic [FRAME_W-1:0] shift_out(input logic [FRAME_W-1:0] v);
    return {v[FRAME_W-2:0], 1'b0};
  endfunction

  logic               sck_p, ssel_n_p;
  logic [CW-1:0]      cnt_q;
  logic [FRAME_W-1:0] rx_q, tx_q;
  logic               drop_q, reload_q;
  logic               sel, sel_on, rise, fall, load, frame_end;

  assign sel       = ~ssel_n_s;
  assign sel_on    = sel & ssel_n_p;
  assign rise      = sel & sck_s & ~sck_p;
  assign fall      = sel & ~sck_s & sck_p;
  assign load      = sel_on | (fall & reload_q);
  assign frame_end = rise & (cnt_q == LAST);

  assign evt_take_o  = load & tx_full_i;
  assign evt_udr_o   = load & ~tx_full_i;
  assign evt_start_o = rise & (cnt_q == '0);
  assign evt_ovr_o   = evt_start_o & rx_full_i;
  assign evt_push_o  = frame_end & ~(drop_q | evt_ovr_o);
  assign push_data_o = shift_in(rx_q, mosi_s);
  assign miso_o      = tx_q[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= 1'b0; ssel_n_p <= 1'b1;
      cnt_q <= '0; rx_q <= '0; tx_q <= '0; drop_q <= 1'b0; reload_q <= 1'b0;
    end else if (!en_i) begin
      sck_p <= 1'b0; ssel_n_p <= 1'b1;
      cnt_q <= '0; rx_q <= '0; tx_q <= '0; drop_q <= 1'b0; reload_q <= 1'b0;
    end else begin
      sck_p    <= sck_s;
      ssel_n_p <= ssel_n_s;
      if (!sel) begin
        cnt_q <= '0; tx_q <= '0; drop_q <= 1'b0; reload_q <= 1'b0;
      end else begin
        if (rise) begin
          rx_q <= shift_in(rx_q, mosi_s);
          if (evt_ovr_o) drop_q <= 1'b1;
          if (frame_end) begin
            cnt_q    <= '0;
            drop_q   <= 1'b0;
            reload_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        if (load) begin
          tx_q     <= tx_full_i ? tx_word_i : '0;
          reload_q <= 1'b0;
        end else if (fall) begin
          tx_q <= shift_out(tx_q);
        end
      end
    end
  end
endmodule

// File: rtl/spi_slave_port.sv
module spi_slave_port #(
  parameter int FRAME_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               sck_i,
  input  logic               mosi_i,
  input  logic               ssel_n_i,
  output logic               miso_o,
  input  logic               tx_wr_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  output logic               tx_ready_o,
  input  logic               rx_rd_i,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               rx_ready_o,
  output logic               ovr_evt_o,
  output logic               udr_evt_o
);
  import spi_slave_pkg::*;

  spi_lines_t raw_lines, syn_lines;
  logic [FRAME_W-1:0] tx_buf_q, rx_buf_q, push_data;
  logic tx_full_q, rx_full_q;
  // Named internal events, brought out for the checker.
  logic evt_start, evt_push, evt_take, evt_udr, evt_ovr;

  assign raw_lines = '{ssel_n: ssel_n_i, sck: sck_i, mosi: mosi_i};

  spi_slave_sync #(.W(LINES_W), .STAGES(SYNC_STAGES), .IDLE(LINES_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .d_i(raw_lines), .q_o(syn_lines)
  );

  spi_slave_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en_i(en_i),
    .sck_s(syn_lines.sck), .ssel_n_s(syn_lines.ssel_n), .mosi_s(syn_lines.mosi),
    .rx_full_i(rx_full_q), .tx_full_i(tx_full_q), .tx_word_i(tx_buf_q),
    .miso_o(miso_o), .evt_start_o(evt_start), .evt_push_o(evt_push),
    .push_data_o(push_data), .evt_take_o(evt_take), .evt_udr_o(evt_udr),
    .evt_ovr_o(evt_ovr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full_q <= 1'b0; tx_buf_q <= '0;
      rx_full_q <= 1'b0; rx_buf_q <= '0;
    end else if (!en_i) begin
      tx_full_q <= 1'b0;
      rx_full_q <= 1'b0;
    end else begin
      if (evt_take) tx_full_q <= 1'b0;
      else if (tx_wr_i && !tx_full_q) begin
        tx_full_q <= 1'b1;
        tx_buf_q  <= tx_data_i;
      end
      if (evt_push) begin
        rx_full_q <= 1'b1;
        rx_buf_q  <= push_data;
      end else if (rx_rd_i) begin
        rx_full_q <= 1'b0;
      end
    end
  end

  assign tx_ready_o = ~tx_full_q;
  assign rx_ready_o = rx_full_q;
  assign rx_data_o  = rx_buf_q;
  assign ovr_evt_o  = evt_ovr;
  assign udr_evt_o  = evt_udr;
endmodule

// File: rtl/spi_slave_port_chk.sv
module spi_slave_port_chk #(
  parameter int FRAME_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en_i,
  input logic               tx_wr_i,
  input logic               tx_ready_o,
  input logic               rx_rd_i,
  input logic               rx_ready_o,
  input logic [FRAME_W-1:0] rx_data_o,
  input logic               miso_o,
  input logic               ovr_evt_o,
  input logic               udr_evt_o,
  input logic               evt_start,
  input logic               evt_push,
  input logic               evt_take
);
  p_idle_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (tx_ready_o && !rx_ready_o && !miso_o && !ovr_evt_o && !udr_evt_o));

  p_push_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_push && en_i) |=> rx_ready_o);

  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_i && rx_ready_o && !evt_push) |=> !rx_ready_o);

  p_write_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_i && tx_ready_o && en_i) |=> !tx_ready_o);

  p_take_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_take |=> tx_ready_o);

  p_ovr_at_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt_o |-> (evt_start && rx_ready_o && !evt_push));

  p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_push |=> $stable(rx_data_o));

  p_udr_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    udr_evt_o |-> (tx_ready_o && !evt_take));
endmodule

bind spi_slave_port spi_slave_port_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .tx_wr_i(tx_wr_i),
  .tx_ready_o(tx_ready_o), .rx_rd_i(rx_rd_i), .rx_ready_o(rx_ready_o),
  .rx_data_o(rx_data_o), .miso_o(miso_o), .ovr_evt_o(ovr_evt_o),
  .udr_evt_o(udr_evt_o), .evt_start(evt_start), .evt_push(evt_push),
  .evt_take(evt_take)
);

// File: tb/spi_slave_port_test.sv
module spi_slave_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK = 10 * CLK_PERIOD;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, ssel_n = 1'b1;
  logic tx_wr = 1'b0, rx_rd = 1'b0;
  logic [7:0] tx_data = '0;
  logic miso, tx_ready, rx_ready, ovr_evt, udr_evt;
  logic [7:0] rx_data;
  int errors = 0, checks = 0, n_ovr = 0, n_udr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_slave_port uut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .sck_i(sck), .mosi_i(mosi),
    .ssel_n_i(ssel_n), .miso_o(miso), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
    .tx_ready_o(tx_ready), .rx_rd_i(rx_rd), .rx_data_o(rx_data),
    .rx_ready_o(rx_ready), .ovr_evt_o(ovr_evt), .udr_evt_o(udr_evt)
  );

  always @(negedge clk) begin
    if (ovr_evt) n_ovr++;
    if (udr_evt) n_udr++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); tx_wr = 1'b1; tx_data = b;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic sel();
    ssel_n = 1'b0;
  endtask

  task automatic desel();
    #(HALF_SCK); ssel_n = 1'b1; #(HALF_SCK);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Master: drives MSB first, samples MISO just before each rising edge.
  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi, input int nbits);
    mi = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi = mo[7-i];
      #(HALF_SCK);
      mi[7-i] = miso;
      sck = 1'b1;
      #(HALF_SCK);
      sck = 1'b0;
    end
  endtask

  task automatic t_reset();
    check("R1 tx_ready", tx_ready, 1); check("R1 rx_ready", rx_ready, 0);
    check("R1 miso", miso, 0);
    check("R1 events", {ovr_evt, udr_evt}, 0);
  endtask

  task automatic t_basic();
    logic [7:0] mi;
    wr(8'hA5);
    check("R4 ready drops", tx_ready, 0);
    sel(); wait_clk(8);
    check("R4 ready rises on load", tx_ready, 1);
    xfer(8'h3C, mi, 8);
    check("R5 miso word", mi, 8'hA5);
    check("R2 rx_ready", rx_ready, 1); check("R2 rx_data", rx_data, 8'h3C);
    desel(); rd();
    check("R3 read clears", rx_ready, 0);
  endtask

  task automatic t_b2b();
    logic [7:0] m1, m2;
    wr(8'h81); sel(); wait_clk(8); wr(8'h7E);
    xfer(8'h12, m1, 8);
    check("R11 frame1 rx", rx_data, 8'h12);
    rd();
    xfer(8'hED, m2, 8);
    check("R11 frame1 miso", m1, 8'h81); check("R11 frame2 miso", m2, 8'h7E);
    check("R11 frame2 rx", rx_data, 8'hED); check("R11 frame2 ready", rx_ready, 1);
    desel(); rd();
  endtask

  task automatic t_ignore();
    logic [7:0] mi;
    wr(8'h4B); wr(8'hFF);
    sel(); xfer(8'h00, mi, 8);
    check("R10 second write ignored", mi, 8'h4B);
    desel(); rd();
  endtask

  task automatic t_abort();
    logic [7:0] mi;
    wr(8'hC3); sel(); xfer(8'hFF, mi, 3); desel();
    check("R8 partial dropped", rx_ready, 0);
    wr(8'h96); sel(); xfer(8'h5A, mi, 8);
    check("R8 realigned miso", mi, 8'h96); check("R8 realigned rx", rx_data, 8'h5A);
    desel(); rd();
  endtask

  task automatic t_overrun();
    logic [7:0] mi;
    int o0;
    o0 = n_ovr;
    wr(8'h00); sel();
    xfer(8'h11, mi, 8);
    check("R6 no overrun on first", n_ovr - o0, 0);
    xfer(8'h22, mi, 8);
    check("R6 overrun pulse", n_ovr - o0, 1);
    check("R6 data kept", rx_data, 8'h11); check("R6 ready kept", rx_ready, 1);
    desel();
    @(negedge clk); en = 1'b0; wait_clk(2);
    check("R9 rx_ready cleared", rx_ready, 0); check("R1 miso while off", miso, 0);
    en = 1'b1; wait_clk(2);
  endtask

  task automatic t_underrun();
    logic [7:0] mi;
    int u0;
    u0 = n_udr;
    sel(); wait_clk(8);
    check("R7 udr pulse at select", n_udr - u0, 1);
    xfer(8'h55, mi, 8);
    check("R7 zeros on miso", mi, 8'h00); check("R2 rx under underrun", rx_data, 8'h55);
    desel();
  endtask

  task automatic t_disable();
    logic [7:0] mi;
    int u0;
    wr(8'hE7);
    @(negedge clk); en = 1'b0; wait_clk(2);
    check("R9 tx_ready after disable", tx_ready, 1); check("R9 rx_ready after disable", rx_ready, 0);
    en = 1'b1; wait_clk(2);
    u0 = n_udr;
    sel(); xfer(8'h33, mi, 8);
    check("R9 held word discarded", mi, 8'h00);
    check("R9 underrun follows", (n_udr - u0) >= 1, 1);
    check("R9 rx after enable", rx_data, 8'h33);
    desel(); rd();
  endtask

  initial begin
    wait_clk(3); rst_n = 1'b1; wait_clk(2);
    t_reset();
    en = 1'b1; wait_clk(4);
    t_reset();
    t_basic(); t_b2b(); t_ignore(); t_abort();
    t_overrun(); t_underrun(); t_disable();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule